// File: doc/BRIEF.md
# LPDDR2/3 Command/Address Decoder

This block sits behind the command/address pins of a low-power DDR memory device model or monitor. It samples a 10-bit command/address bus twice per clock, once on the rising edge and once on the falling edge. It then combines the two half-cycle samples into one decoded command. The opcode sits in the lowest bits of the rising sample. Bank, row, column, mode-register address and data, and the auto-precharge and all-banks qualifiers are collected from fixed bit positions that span both halves.

A command counts only when the select input is high at the rising edge. The decoded result is presented for one clock. It carries a valid strobe and has no back-pressure, because a command bus cannot be stalled, so whatever consumes it must take every result in the cycle it appears. Per-bank refresh does not carry a bank. The decoder keeps a round-robin pointer and reports the bank that the refresh hits. A build-time variant selects the non-volatile device decoding, in which two opcodes carry wide address pieces instead of the volatile-memory meaning.

Top module: `lpddr_ca_decoder`

## Requirements
- R1: While reset is held and after its release, before any selected command, `cmd_valid_o` is 0, `cmd_type_o` is 0 (no operation) and the refresh pointer is 0.
- R2: A command whose rising half is sampled at clock edge k, with its falling half at the falling edge that follows, appears on the outputs after rising edge k+1. A new command can be accepted every cycle.
- R3: If `cs_i` is low at a rising edge, the result one cycle later has `cmd_valid_o`=0, type 0 and every field 0, whatever the falling sample holds. The refresh pointer does not move, even if the bus carries a refresh pattern.
- R4: Rising CA0, CA1 and CA2 all high gives a valid command of type 0 (no operation), regardless of the other bits.
- R5: Rising CA0..CA3 = 1,1,0,1 gives type 1 (precharge). Rising CA4=1 sets `all_banks_o` and reports bank 0. CA4=0 reports bank = rising CA9..CA7 (CA7 is the bank LSB).
- R6: Rising CA0..CA3 = 1,1,0,0 gives type 2 (burst terminate) with all fields 0.
- R7: Rising CA0..CA2 = 1,0,1 gives type 3 (read) and 1,0,0 gives type 4 (write), with rising CA3 = 0. Bank = rising CA9..CA7. `auto_pre_o` = falling CA0. Column bits 2:1 = rising CA5:CA4, column bits 11:3 = falling CA9:CA1, and column bit 0 = 0.
- R8: Rising CA0=0 and CA1=1 gives type 5 (activate). Bank = rising CA9..CA7. Row bits 12:8 = rising CA6:CA2, row bits 7:0 = falling CA7:CA0, and row bits 14:13 = falling CA9:CA8.
- R9: Rising CA0..CA2 = 0,0,1 gives type 6 (refresh). Rising CA3=1 sets `all_banks_o` with bank 0. Rising CA3=0 reports the pointer value as the bank, and the pointer then advances by one, wrapping from 7 to 0.
- R10: Rising CA0..CA3 = 0,0,0,1 gives type 7 (mode-register read) and 0,0,0,0 gives type 8 (mode-register write). Register address bits 5:0 = rising CA9:CA4 and bits 7:6 = falling CA1:CA0. For a write only, data = falling CA9:CA2. A read reports data 0.
- R11: A read or write pattern with rising CA3=1 (the reserved bit set) gives type 15 (illegal) with all fields 0, and it leaves the refresh pointer unchanged.
- R12: With `NVM_VARIANT`=1, pattern 1,1,0,1 gives type 9 (preactive) with bank = rising CA9..CA7 and row = {rising CA6:CA4, falling CA9:CA0} zero-extended. Pattern 0,1 gives type 10 (non-volatile activate) with bank = rising CA9..CA7 and row = {rising CA6:CA2, falling CA9:CA0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges sample `ca_i` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Command select, sampled on the rising edge, active high |
| ca_i | input | 10 | Command/address bus, bit n is CAn |
| cmd_valid_o | output | 1 | Decoded command present this cycle |
| cmd_type_o | output | 4 | Command type code (see requirements) |
| bank_o | output | 3 | Bank address |
| row_o | output | 15 | Row address (or wide address piece in the non-volatile variant) |
| col_o | output | 12 | Column address, bit 0 always 0 |
| mr_addr_o | output | 8 | Mode-register address |
| mr_data_o | output | 8 | Mode-register write data |
| auto_pre_o | output | 1 | Auto-precharge qualifier of read/write |
| all_banks_o | output | 1 | All-banks qualifier of precharge/refresh |

## Verification
Every result is due exactly one clock after the rising edge that captured the first half of its command, and the falling half lands half a cycle before that. The bench drives the rising half just after a falling edge and the falling half just after the rising edge. The expected item enters the scoreboard at that second moment. At each rising edge the monitor notes how many items were queued before the driver could add one, and it compares the outputs in the middle of that cycle. Commands therefore pair with their results even when they arrive back to back. A second instance built with the non-volatile variant receives the same bus and is scored on type, bank and, for the variant opcodes, row.

// File: rtl/lpddr_ca_pkg.sv
package lpddr_ca_pkg;
  localparam int CA_W   = 10;
  localparam int BANK_W = 3;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int ROW_W  = 15;
  localparam int COL_W  = 12;
  localparam int MR_W   = 8;
  localparam int TYPE_W = 4;

  typedef enum logic [TYPE_W-1:0] {
    CMD_NOP    = 4'd0,
    CMD_PRE    = 4'd1,
    CMD_BST    = 4'd2,
    CMD_RD     = 4'd3,
    CMD_WR     = 4'd4,
    CMD_ACT    = 4'd5,
    CMD_REF    = 4'd6,
    CMD_MRR    = 4'd7,
    CMD_MRW    = 4'd8,
    CMD_PREACT = 4'd9,
    CMD_ACTNV  = 4'd10,
    CMD_ILL    = 4'd15
  } cmd_e;

  typedef struct packed {
    logic              valid;
    cmd_e              kind;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [MR_W-1:0]   ma;
    logic [MR_W-1:0]   op;
    logic              ap;
    logic              ab;
  } dec_cmd_t;
endpackage

// File: rtl/lpddr_ca_capture.sv
module lpddr_ca_capture
  import lpddr_ca_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_i,
  input  logic [CA_W-1:0] ca_i,
  output logic            rise_cs_q,
  output logic [CA_W-1:0] rise_ca_q,
  output logic [CA_W-1:0] fall_ca_q
);
  // First half of the command: opcode, select and upper fields.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cs_q <= 1'b0;
      rise_ca_q <= '0;
    end else begin
      rise_cs_q <= cs_i;
      rise_ca_q <= ca_i;
    end
  end

  // Second half, taken mid-cycle; select plays no part here.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_ca_q <= '0;
    else        fall_ca_q <= ca_i;
  end
endmodule

// File: rtl/lpddr_ca_refresh_ptr.sv
module lpddr_ca_refresh_ptr
  import lpddr_ca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [BANK_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_o <= '0;
    else if (adv_i) ptr_o <= ptr_o + 1'b1;
  end

  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && ptr_o == BANK_W'(NUM_BANKS-1)) |=> (ptr_o == '0));
endmodule

// File: rtl/lpddr_ca_field_decode.sv
module lpddr_ca_field_decode
  import lpddr_ca_pkg::*;
#(
  parameter bit NVM_VARIANT = 1'b0
) (
  input  logic              sel_i,
  input  logic [CA_W-1:0]   r_i,
  input  logic [CA_W-1:0]   f_i,
  input  logic [BANK_W-1:0] ptr_i,
  output dec_cmd_t          cmd_o,
  output logic              adv_o
);
  logic is_nop, is_pre_grp, is_bst, is_rw, is_act_grp, is_ref, is_mr;

  always_comb begin
    is_nop     = r_i[0] &  r_i[1] &  r_i[2];
    is_pre_grp = r_i[0] &  r_i[1] & ~r_i[2] &  r_i[3];
    is_bst     = r_i[0] &  r_i[1] & ~r_i[2] & ~r_i[3];
    is_rw      = r_i[0] & ~r_i[1];
    is_act_grp = ~r_i[0] &  r_i[1];
    is_ref     = ~r_i[0] & ~r_i[1] &  r_i[2];
    is_mr      = ~r_i[0] & ~r_i[1] & ~r_i[2];
  end

  // Variant-specific meaning of the precharge and activate groups.
  dec_cmd_t pre_grp, act_grp;
  generate
    if (NVM_VARIANT) begin : g_nvm
      always_comb begin
        pre_grp      = '0;
        pre_grp.kind = CMD_PREACT;
        pre_grp.bank = r_i[9:7];
        pre_grp.row  = ROW_W'({r_i[6:4], f_i});
        act_grp      = '0;
        act_grp.kind = CMD_ACTNV;
        act_grp.bank = r_i[9:7];
        act_grp.row  = {r_i[6:2], f_i};
      end
    end else begin : g_vol
      always_comb begin
        pre_grp      = '0;
        pre_grp.kind = CMD_PRE;
        pre_grp.ab   = r_i[4];
        pre_grp.bank = r_i[4] ? '0 : r_i[9:7];
        act_grp      = '0;
        act_grp.kind = CMD_ACT;
        act_grp.bank = r_i[9:7];
        act_grp.row  = {f_i[9:8], r_i[6:2], f_i[7:0]};
      end
    end
  endgenerate

  always_comb begin
    cmd_o = '0;
    adv_o = 1'b0;
    if (sel_i) begin
      if (is_nop) begin
        cmd_o.kind = CMD_NOP;
      end else if (is_pre_grp) begin
        cmd_o = pre_grp;
      end else if (is_bst) begin
        cmd_o.kind = CMD_BST;
      end else if (is_rw) begin
        if (r_i[3]) begin
          cmd_o.kind = CMD_ILL;
        end else begin
          cmd_o.kind = r_i[2] ? CMD_RD : CMD_WR;
          cmd_o.bank = r_i[9:7];
          cmd_o.ap   = f_i[0];
          cmd_o.col  = {f_i[9:1], r_i[5:4], 1'b0};
        end
      end else if (is_act_grp) begin
        cmd_o = act_grp;
      end else if (is_ref) begin
        cmd_o.kind = CMD_REF;
        if (r_i[3]) begin
          cmd_o.ab = 1'b1;
        end else begin
          cmd_o.bank = ptr_i;
          adv_o      = 1'b1;
        end
      end else if (is_mr) begin
        cmd_o.kind = r_i[3] ? CMD_MRR : CMD_MRW;
        cmd_o.ma   = {f_i[1:0], r_i[9:4]};
        if (!r_i[3]) cmd_o.op = f_i[9:2];
      end
      cmd_o.valid = 1'b1;
    end
  end
endmodule

// File: rtl/lpddr_ca_decoder.sv
module lpddr_ca_decoder
  import lpddr_ca_pkg::*;
#(
  parameter bit NVM_VARIANT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_i,
  input  logic [CA_W-1:0]    ca_i,
  output logic               cmd_valid_o,
  output logic [TYPE_W-1:0]  cmd_type_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [COL_W-1:0]   col_o,
  output logic [MR_W-1:0]    mr_addr_o,
  output logic [MR_W-1:0]    mr_data_o,
  output logic               auto_pre_o,
  output logic               all_banks_o
);
  logic              rise_cs;
  logic [CA_W-1:0]   rise_ca, fall_ca;
  logic [BANK_W-1:0] ptr_q;
  logic              adv;
  dec_cmd_t          dec, out_q;

  lpddr_ca_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs_i),
    .ca_i      (ca_i),
    .rise_cs_q (rise_cs),
    .rise_ca_q (rise_ca),
    .fall_ca_q (fall_ca)
  );

  lpddr_ca_field_decode #(.NVM_VARIANT(NVM_VARIANT)) u_decode (
    .sel_i (rise_cs),
    .r_i   (rise_ca),
    .f_i   (fall_ca),
    .ptr_i (ptr_q),
    .cmd_o (dec),
    .adv_o (adv)
  );

  lpddr_ca_refresh_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv),
    .ptr_o (ptr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= dec;
  end

  assign cmd_valid_o = out_q.valid;
  assign cmd_type_o  = out_q.kind;
  assign bank_o      = out_q.bank;
  assign row_o       = out_q.row;
  assign col_o       = out_q.col;
  assign mr_addr_o   = out_q.ma;
  assign mr_data_o   = out_q.op;
  assign auto_pre_o  = out_q.ap;
  assign all_banks_o = out_q.ab;

  assert_unselected_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_cs |=> (!cmd_valid_o && cmd_type_o == CMD_NOP && bank_o == '0));

  assert_refpb_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_type_o == CMD_REF && !all_banks_o) |->
      (bank_o == BANK_W'(ptr_q - 1'b1)));

  assert_ab_scope_R5: assert property (@(posedge clk) disable iff (!rst_n)
    all_banks_o |-> (cmd_type_o == CMD_PRE || cmd_type_o == CMD_REF));

  assert_ap_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_o |-> (cmd_type_o == CMD_RD || cmd_type_o == CMD_WR));

  assert_illegal_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_type_o == CMD_ILL) |-> (ptr_q == $past(ptr_q)));
endmodule

// File: tb/test_lpddr_ca_decoder.sv
module test_lpddr_ca_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic [9:0] ca = '0;

  always #2.5 clk = ~clk;

  logic v0, v1, ap0, ap1, ab0, ab1;
  logic [3:0] t0, t1;
  logic [2:0] b0, b1;
  logic [14:0] row0, row1;
  logic [11:0] col0, col1;
  logic [7:0] ma0, ma1, op0, op1;

  lpddr_ca_decoder i_lpddr_ca_decoder (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .ca_i(ca),
    .cmd_valid_o(v0), .cmd_type_o(t0), .bank_o(b0), .row_o(row0), .col_o(col0),
    .mr_addr_o(ma0), .mr_data_o(op0), .auto_pre_o(ap0), .all_banks_o(ab0));

  lpddr_ca_decoder #(.NVM_VARIANT(1'b1)) i_lpddr_ca_decoder_nvm (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .ca_i(ca),
    .cmd_valid_o(v1), .cmd_type_o(t1), .bank_o(b1), .row_o(row1), .col_o(col1),
    .mr_addr_o(ma1), .mr_data_o(op1), .auto_pre_o(ap1), .all_banks_o(ab1));

  localparam logic [3:0] T_NOP = 4'd0, T_PRE = 4'd1, T_BST = 4'd2, T_RD = 4'd3,
    T_WR = 4'd4, T_ACT = 4'd5, T_REF = 4'd6, T_MRR = 4'd7, T_MRW = 4'd8,
    T_PREACT = 4'd9, T_ACTNV = 4'd10, T_ILL = 4'd15;

  typedef struct {
    logic v; logic [3:0] t; logic [2:0] b; logic [14:0] row; logic [11:0] col;
    logic [7:0] ma; logic [7:0] op; logic ap; logic ab;
    logic [3:0] nt; logic nchk; logic [14:0] nrow; string req;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t mk(string req, logic v, logic [3:0] t);
    exp_t e;
    e.v = v; e.t = t; e.b = '0; e.row = '0; e.col = '0; e.ma = '0; e.op = '0;
    e.ap = 1'b0; e.ab = 1'b0; e.nt = t; e.nchk = 1'b0; e.nrow = '0; e.req = req;
    return e;
  endfunction

  task automatic send(input logic sel, input logic [9:0] rh, input logic [9:0] fh, input exp_t e);
    @(negedge clk); #1;
    cs = sel; ca = rh;
    @(posedge clk); #1;
    ca = fh; cs = ~sel;
    sb.push_back(e);
  endtask

  task automatic idle(input logic [9:0] rh, input logic [9:0] fh);
    send(1'b0, rh, fh, mk("R3", 1'b0, T_NOP));
  endtask

  task automatic refpb(input logic [2:0] bank, input string req);
    exp_t e = mk(req, 1'b1, T_REF);
    e.b = bank;
    send(1'b1, 10'h004, 10'h3FF, e);
  endtask

  // Monitor: pairs each result with the command queued before this edge.
  initial begin
    forever begin
      int n;
      logic [52:0] act, exp_v;
      exp_t e;
      @(posedge clk);
      n = sb.size();
      #2;
      if (n > 0) begin
        e = sb.pop_front();
        act   = {v0, t0, b0, row0, col0, ma0, op0, ap0, ab0};
        exp_v = {e.v, e.t, e.b, e.row, e.col, e.ma, e.op, e.ap, e.ab};
        checks++;
        if (act !== exp_v) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", e.req, act, exp_v);
        end
        checks++;
        if ({v1, t1, b1} !== {e.v, e.nt, e.b} || (e.nchk && row1 !== e.nrow)) begin
          errors++;
          $display("FAIL %s (R12 variant): actual %h/%h expected %h/%h",
                   e.req, {v1, t1, b1}, row1, {e.v, e.nt, e.b}, e.nrow);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    logic [11:0] col;
    logic [14:0] row;
    repeat (3) @(posedge clk);
    #1;
    checks++; // R1 reset state
    if (v0 !== 1'b0 || t0 !== T_NOP) begin
      errors++;
      $display("FAIL R1: actual %b/%h expected 0/0", v0, t0);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    checks++; // R1 after release
    if (v0 !== 1'b0 || t0 !== T_NOP || b0 !== 3'd0) begin
      errors++;
      $display("FAIL R1: actual %b/%h/%h expected 0/0/0", v0, t0, b0);
    end

    idle(10'h3A7, 10'h3FF);
    // R4 no operation, junk in the other bits
    send(1'b1, 10'h3A7, 10'h155, mk("R4", 1'b1, T_NOP));
    // R5 precharge all banks
    e = mk("R5", 1'b1, T_PRE); e.ab = 1'b1; e.nt = T_PREACT;
    send(1'b1, 10'h01B, 10'h000, e);
    // R5 precharge bank 5; variant sees preactive (R12)
    e = mk("R5", 1'b1, T_PRE); e.b = 3'd5; e.nt = T_PREACT; e.nchk = 1'b1; e.nrow = 15'h02A5;
    send(1'b1, {3'd5, 3'b000, 4'b1011}, 10'h2A5, e);
    // R6 burst terminate
    send(1'b1, 10'h003, 10'h3FF, mk("R6", 1'b1, T_BST));
    // R7 read with auto-precharge
    col = 12'h9A6;
    e = mk("R7", 1'b1, T_RD); e.b = 3'd3; e.col = col; e.ap = 1'b1;
    send(1'b1, {3'd3, 1'b0, col[2:1], 1'b0, 3'b101}, {col[11:3], 1'b1}, e);
    // R7 write without auto-precharge
    col = 12'h152;
    e = mk("R7", 1'b1, T_WR); e.b = 3'd6; e.col = col;
    send(1'b1, {3'd6, 1'b0, col[2:1], 1'b0, 3'b001}, {col[11:3], 1'b0}, e);
    // R8 activate; variant sees wide activate (R12)
    row = 15'h5A3C;
    e = mk("R8", 1'b1, T_ACT); e.b = 3'd2; e.row = row; e.nt = T_ACTNV; e.nchk = 1'b1;
    e.nrow = {row[12:8], row[14:13], row[7:0]};
    send(1'b1, {3'd2, row[12:8], 2'b10}, {row[14:13], row[7:0]}, e);
    // R9 per-bank refresh walks the pointer
    refpb(3'd0, "R9");
    refpb(3'd1, "R9");
    refpb(3'd2, "R9");
    // R11 reserved bit set on read
    send(1'b1, {3'd7, 1'b0, 2'b11, 1'b1, 3'b101}, 10'h3FF, mk("R11", 1'b1, T_ILL));
    refpb(3'd3, "R11");
    // R3 unselected refresh pattern is ignored
    idle(10'h004, 10'h2AA);
    refpb(3'd4, "R3");
    // R9 all-bank refresh does not use the pointer
    e = mk("R9", 1'b1, T_REF); e.ab = 1'b1;
    send(1'b1, 10'h00C, 10'h3FF, e);
    refpb(3'd5, "R9");
    refpb(3'd6, "R9");
    refpb(3'd7, "R9");
    refpb(3'd0, "R9");
    // R10 mode-register read: data bits ignored
    e = mk("R10", 1'b1, T_MRR); e.ma = 8'hC5;
    send(1'b1, {6'h05, 4'b1000}, {8'hFF, 2'b11}, e);
    // R10 mode-register write
    e = mk("R10", 1'b1, T_MRW); e.ma = 8'h3A; e.op = 8'h96;
    send(1'b1, {6'h3A, 4'b0000}, {8'h96, 2'b00}, e);
    // R2 back-to-back after a gap
    idle(10'h000, 10'h000);
    send(1'b1, 10'h3FF, 10'h000, mk("R2", 1'b1, T_NOP));
    send(1'b1, 10'h003, 10'h000, mk("R2", 1'b1, T_BST));
    idle(10'h000, 10'h000);
    idle(10'h000, 10'h000);
    while (sb.size() != 0) @(posedge clk);
    @(posedge clk); #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule